// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is a bus master for a time-multiplexed address/data bus. A requester hands it one transaction at a time through a valid/ready handshake. Each transaction carries an address, write data, a read/write flag and a memory/port flag. The sequencer turns it into a four-clock bus cycle made of phases T1, T2, T3 and T4. In T1 the shared lines carry the address while the address strobe is high, so external latches can capture it on the strobe's falling edge. T2 turns the bus around. Data moves in T3 and T4. Read data is sampled from the bus at the end of T4 and handed back with a one-clock valid pulse.

A second master can ask for the bus through a hold request. The request passes through a two-stage synchronizer. The sequencer yields the bus only at a cycle boundary, which is the end of T4 or an idle clock. While it has yielded, it raises the hold acknowledge and drops the output enables of every control line and of the shared lines. Tri-state is expressed as separate enable outputs, so the pad ring can build the bidirectional pins.

States: `ST_IDLE`, `ST_T1`, `ST_T2`, `ST_T3`, `ST_T4`, `ST_HOLD`. Transitions:
- IDLE→T1 when a request is accepted.
- IDLE→HOLD when the synchronized hold is high.
- T1→T2, T2→T3 and T3→T4 unconditionally.
- T4→HOLD when hold is high.
- T4→T1 when a request is accepted.
- T4→IDLE otherwise.
- HOLD stays in HOLD while hold is high.
- HOLD→T1 when hold has dropped and a request is accepted.
- HOLD→IDLE when hold has dropped and no request is waiting.

Top module: `mux_bus_seq`

## Requirements
- R1: During and just after reset: `ale`=0, `rd_n`=1, `wr_n`=1, `hlda`=0, `ctl_oe`=1, `ad_oe`=0, `rsp_valid`=0, `req_ready`=1.
- R2: Every bus cycle lasts exactly four clocks (T1..T4). When a new request is accepted in T4, its T1 follows on the very next clock, so back-to-back address strobes are four clocks apart.
- R3: In T1, `ale`=1 for exactly one clock and `ad_oe`=1. For a memory cycle `ad_out` carries the full 20-bit address. For a port cycle (`req_mem`=0), bits 19..16 are 0 and bits 15..0 carry the address.
- R4: In a read, `rd_n` is low in T2 and T3 only, `ad_oe` is 0 from T2 to T4, and `dtr` is 0 from T1 to T4.
- R5: In a write, `wr_n` is low in T2 and T3 only, `ad_oe` is 1 from T1 to T4 with `ad_out` = {4'h0, write data} from T2 to T4, and `dtr` is 1 from T1 to T4.
- R6: Read data is sampled from `ad_in` at the clock edge that ends T4. It appears on `rsp_rdata` with `rsp_valid` high for exactly one clock right after T4. Writes give no response.
- R7: `mio` is 1 for memory and 0 for port. It holds the current cycle's type through T1..T3. In the clock where the next request is accepted (T4 or idle), it already shows the new request's type.
- R8: `hold_in` is used only after two synchronizing flops. The bus is released only from IDLE or at the end of T4, never mid-cycle. While `hlda`=1: `ctl_oe`=0, `ad_oe`=0 and `req_ready`=0 for as long as the synchronized hold stays high.
- R9: After the synchronized hold drops, `req_ready` rises in the last HOLD clock. A waiting request is accepted then, and its T1 is the next clock, with `hlda`=0.
- R10: `req_ready` is high only in IDLE, T4 or HOLD, and only while the synchronized hold is low. A request that is held valid while `req_ready`=0 produces no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transaction request valid |
| req_ready | output | 1 | Sequencer can accept a request this clock |
| req_addr | input | 20 | Transaction address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = port space |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 16 | Read data |
| hold_in | input | 1 | Asynchronous bus request from another master |
| hlda | output | 1 | Bus released to the other master |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mio | output | 1 | Memory (1) or port (0) cycle |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| ctl_oe | output | 1 | Enable for rd_n, wr_n, mio, dtr pads |
| ad_out | output | 20 | Value driven on the shared lines |
| ad_oe | output | 1 | Enable for the shared lines |
| ad_in | input | 16 | Value sampled from the shared lines |

## Verification
The in-RTL properties watch the following on every cycle:
- the one-clock address strobe;
- the two-clock shape of each read and write strobe;
- that the shared lines are never driven while the read strobe is low;
- high impedance throughout hold;
- that entry into HOLD comes only from IDLE or T4;
- single-pulse responses;
- that an accepted request is followed by T1.

Other behaviour depends on concrete data and is shown only by the bench's scenarios. This covers the address and data values in each phase, the zeroed upper bits on port cycles, `mio` showing the next type early, and the read data matching what an earlier write left in the memory model. It also covers the exact synchronizer latency and the restart timing after hold is released.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4,
        ST_HOLD
    } mbs_state_e;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbs_seq_fsm.sv
module mbs_seq_fsm
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_s,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [DATA_W-1:0] ad_in,
    output mbs_state_e        state,
    output logic              req_ready,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              cur_write,
    output logic              cur_mem,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    mbs_state_e state_nx;
    logic       accept;

    assign req_ready = !hold_s &&
                       (state == ST_IDLE || state == ST_T4 || state == ST_HOLD);
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (hold_s)      state_nx = ST_HOLD;
                     else if (accept) state_nx = ST_T1;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_T3;
            ST_T3:   state_nx = ST_T4;
            ST_T4:   if (hold_s)      state_nx = ST_HOLD;
                     else if (accept) state_nx = ST_T1;
                     else             state_nx = ST_IDLE;
            ST_HOLD: if (hold_s)      state_nx = ST_HOLD;
                     else if (accept) state_nx = ST_T1;
                     else             state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_write <= 1'b0;
            cur_mem   <= 1'b1;
        end else if (accept) begin
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            cur_write <= req_write;
            cur_mem   <= req_mem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_T4) && !cur_write;
            if ((state == ST_T4) && !cur_write) rsp_rdata <= ad_in;
        end
    end

    // R8: the bus is yielded only from an idle clock or the end of T4
    a_r8_release_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) != ST_HOLD) |->
        ($past(state) == ST_T4 || $past(state) == ST_IDLE));

    // R6: a response is a single-clock pulse
    a_r6_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: an accepted request always starts with T1
    a_r10_accept_starts_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> state == ST_T1);
endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int IO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mbs_state_e        state,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_wdata,
    input  logic              cur_write,
    input  logic              cur_mem,
    input  logic              req_valid,
    input  logic              req_ready,
    input  logic              req_mem,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              mio,
    output logic              dtr,
    output logic              ctl_oe,
    output logic              hlda,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe
);
    localparam int IO_PAD  = ADDR_W - IO_W;
    localparam int DAT_PAD = ADDR_W - DATA_W;

    logic in_data_phase;
    assign in_data_phase = (state == ST_T2) || (state == ST_T3) || (state == ST_T4);

    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad_oe  = 1'b0;
        ad_out = '0;
        ctl_oe = (state != ST_HOLD);
        hlda   = (state == ST_HOLD);
        dtr    = (state == ST_IDLE) ? 1'b1 : cur_write;
        mio    = cur_mem;
        unique case (state)
            ST_IDLE: if (req_valid && req_ready) mio = req_mem;
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = cur_mem ? cur_addr : {{IO_PAD{1'b0}}, cur_addr[IO_W-1:0]};
            end
            ST_T2, ST_T3: begin
                rd_n = cur_write;
                wr_n = !cur_write;
            end
            ST_T4:   if (req_valid && req_ready) mio = req_mem;
            ST_HOLD: dtr = 1'b0;
            default: ;
        endcase
        if (in_data_phase && cur_write) begin
            ad_oe  = 1'b1;
            ad_out = {{DAT_PAD{1'b0}}, cur_wdata};
        end
    end

    // R3: address strobe lasts one clock
    a_r3_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> !ale);

    // R4: read strobe low for exactly two clocks
    a_r4_rd_two_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |=> !rd_n);
    a_r4_rd_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !$past(rd_n)) |=> rd_n);
    a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R5: write strobe low for exactly two clocks
    a_r5_wr_two_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |=> !wr_n);
    a_r5_wr_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !$past(wr_n)) |=> wr_n);

    // R8: nothing driven while the bus is released
    a_r8_hold_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ctl_oe && !ad_oe));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int IO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_mem,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              hold_in,
    output logic              hlda,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              mio,
    output logic              dtr,
    output logic              ctl_oe,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in
);
    logic              hold_s;
    mbs_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_write;
    logic              cur_mem;

    mbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(hold_in), .q(hold_s)
    );

    mbs_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hold_s(hold_s),
        .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_write(req_write), .req_mem(req_mem), .ad_in(ad_in),
        .state(state), .req_ready(req_ready),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata),
        .cur_write(cur_write), .cur_mem(cur_mem),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    mbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_W(IO_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .state(state),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata),
        .cur_write(cur_write), .cur_mem(cur_mem),
        .req_valid(req_valid), .req_ready(req_ready), .req_mem(req_mem),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .dtr(dtr),
        .ctl_oe(ctl_oe), .hlda(hlda), .ad_out(ad_out), .ad_oe(ad_oe)
    );
endmodule

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b1;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        hold_in = 1'b0;
    logic        hlda, ale, rd_n, wr_n, mio, dtr, ctl_oe, ad_oe;
    logic [19:0] ad_out;
    logic [15:0] ad_in;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [15:0] mem_arr [512];
    logic [15:0] shadow  [512];
    logic [19:0] lat_addr = '0;
    logic        lat_mio = 1'b1;
    logic [15:0] exp_q [$];

    always #2 clk = ~clk;

    mux_bus_seq u_mux_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_mem(req_mem), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .hold_in(hold_in), .hlda(hlda), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .mio(mio), .dtr(dtr), .ctl_oe(ctl_oe), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in)
    );

    function automatic logic [15:0] init_val(int i);
        return 16'(i * 257) ^ 16'h5A5A;
    endfunction

    function automatic logic [19:0] bus_addr(logic mem, logic [19:0] a);
        return mem ? a : {4'h0, a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // memory model: latches address on the strobe, stores on write strobe
    always @(negedge clk) begin
        if (ale) begin
            lat_addr <= ad_out;
            lat_mio  <= mio;
        end
        if (!wr_n) mem_arr[{lat_mio, lat_addr[7:0]}] <= ad_out[15:0];
    end
    assign ad_in = mem_arr[{lat_mio, lat_addr[7:0]}];

    // R6 response monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected response", 32'(rsp_rdata), 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e, "R6 read data", 32'(rsp_rdata), 32'(e));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R2 watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // called at a negedge; returns at the T4 negedge
    task automatic do_txn(input logic wr, input logic mem, input logic [19:0] a,
                          input logic [15:0] d);
        logic [8:0] key;
        key = {mem, a[7:0]};
        req_valid = 1'b1; req_write = wr; req_mem = mem;
        req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        if (ctl_oe) chk(mio == mem, "R7 early type", 32'(mio), 32'(mem));
        if (wr) shadow[key] = d;
        else    exp_q.push_back(shadow[key]);
        @(negedge clk);
        req_valid = 1'b0;
        chk(ale == 1'b1, "R3 strobe in T1", 32'(ale), 1);
        chk(ad_oe == 1'b1, "R3 drive in T1", 32'(ad_oe), 1);
        chk(ad_out == bus_addr(mem, a), "R3 address", 32'(ad_out), 32'(bus_addr(mem, a)));
        chk(mio == mem, "R7 type in T1", 32'(mio), 32'(mem));
        chk(dtr == wr, wr ? "R5 direction" : "R4 direction", 32'(dtr), 32'(wr));
        chk(hlda == 1'b0, "R9 no hold in T1", 32'(hlda), 0);
        for (int p = 2; p <= 3; p++) begin
            @(negedge clk);
            chk(ale == 1'b0, "R3 strobe off", 32'(ale), 0);
            if (wr) begin
                chk({rd_n, wr_n} == 2'b10, "R5 strobes", 32'({rd_n, wr_n}), 32'h2);
                chk(ad_oe && ad_out == {4'h0, d}, "R5 data", 32'(ad_out), 32'({4'h0, d}));
            end else begin
                chk({rd_n, wr_n} == 2'b01, "R4 strobes", 32'({rd_n, wr_n}), 32'h1);
                chk(ad_oe == 1'b0, "R4 released", 32'(ad_oe), 0);
            end
            chk(mio == mem, "R7 type held", 32'(mio), 32'(mem));
        end
        @(negedge clk);
        chk({rd_n, wr_n} == 2'b11, "R2 strobes off in T4", 32'({rd_n, wr_n}), 32'h3);
        chk(ad_oe == wr, wr ? "R5 data T4" : "R4 released T4", 32'(ad_oe), 32'(wr));
        chk(dtr == wr, wr ? "R5 direction T4" : "R4 direction T4", 32'(dtr), 32'(wr));
        chk(hlda == 1'b0, "R8 no release mid cycle", 32'(hlda), 0);
    endtask

    initial begin
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 512; i++) begin
            mem_arr[i] = init_val(i);
            shadow[i]  = init_val(i);
        end
        @(negedge clk);
        chk(ale == 0 && rd_n && wr_n && !hlda && ctl_oe && !ad_oe && !rsp_valid,
            "R1 reset outputs", 32'({ale, rd_n, wr_n, hlda, ctl_oe, ad_oe}), 32'h1A);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(rd_n && wr_n && !ale, "R1 idle strobes", 32'({ale, rd_n, wr_n}), 3);

        // directed memory and port cycles, back to back (R2)
        do_txn(1'b1, 1'b1, 20'h4_0012, 16'hA5A5);
        do_txn(1'b0, 1'b1, 20'h4_0012, 16'h0);
        do_txn(1'b1, 1'b0, 20'hF_1234, 16'h1357);
        do_txn(1'b0, 1'b0, 20'hA_0034, 16'h0);
        // R2: next accepted request starts right after T4
        do_txn(1'b0, 1'b1, 20'h8_0077, 16'h0);
        @(negedge clk);
        chk(ale == 1'b0 && rsp_valid == 1'b1, "R6 response after T4", 32'({ale, rsp_valid}), 1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R6 single pulse", 32'(rsp_valid), 0);

        // hold from idle (R8)
        hold_in = 1'b1;
        n = 0;
        while (!hlda && n < 10) begin @(negedge clk); n++; end
        chk(n == 3, "R8 sync latency", 32'(n), 3);
        chk(!ctl_oe && !ad_oe && !req_ready, "R8 hiz in hold",
            32'({ctl_oe, ad_oe, req_ready}), 0);
        req_valid = 1'b1; req_write = 1'b0; req_mem = 1'b1; req_addr = 20'h4_0012;
        repeat (3) begin
            @(negedge clk);
            chk(!ale && !req_ready && hlda, "R10 ignored while held",
                32'({ale, req_ready, hlda}), 1);
        end
        hold_in = 1'b0;
        @(negedge clk);
        chk(hlda && !req_ready, "R9 still held one clock", 32'({hlda, req_ready}), 2);
        @(negedge clk);
        chk(hlda && req_ready, "R9 ready in last hold clock", 32'({hlda, req_ready}), 3);
        do_txn(1'b0, 1'b1, 20'h4_0012, 16'h0);

        // hold raised during T1: release only after T4 (R8)
        fork
            do_txn(1'b1, 1'b1, 20'h2_0099, 16'hBEEF);
            begin @(negedge clk); #1; hold_in = 1'b1; end
        join
        @(negedge clk);
        chk(hlda == 1'b1, "R8 release after T4", 32'(hlda), 1);
        hold_in = 1'b0;
        while (hlda) @(negedge clk);
        do_txn(1'b0, 1'b1, 20'h2_0099, 16'h0);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic w, m;
            logic [19:0] a;
            w = 1'($urandom % 2);
            m = 1'($urandom % 2);
            a = 20'($urandom);
            a[7:4] = 4'($urandom % 2);
            do_txn(w, m, a, 16'($urandom));
            repeat ($urandom % 3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads answered", 32'(exp_q.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule